// File: doc/BRIEF.md
# CAS Command Spacing Gate

This block sits between a DDR4 command scheduler and the PHY command path. It receives one column command at a time (read or write, aimed at one of up to four ranks) over a valid/ready handshake. It passes the command on only when every spacing rule that applies to it has run out. The rules keep the DRAM within its column timing. They also keep the shared bidirectional DQ/DQS lines from being driven by two parties at once, with margin sized for a worst-case board that still follows the layout guidelines.

Read latency, write latency, burst length, the write-to-read recovery time and the column-to-column delay are configuration inputs, all in DRAM clocks. They are expected to stay stable while commands flow. Each rule is kept as its own saturating down counter: a global column counter, a global read-to-write counter, and one read-blocking counter per rank. An issued command reloads the relevant counters in the cycle it leaves. A counter never drops below the time still owed to an earlier command, so when several rules apply the longest one decides and the gaps are never added together. Reset clears all history.

Top module: `cas_spacing_gate`

## Requirements
- R1: A write to any rank issues no sooner than RL + BL/2 + 4 - WL clocks after the most recent read (value taken as 0 if negative).
- R2: A read issues no sooner than 6 clocks after a read to a different rank.
- R3: A read issues no sooner than 6 clocks after a write to a different rank.
- R4: A read issues no sooner than WL + BL/2 + tWTR clocks after a write to the same rank.
- R5: Any two column commands, whatever their type and rank, are at least tCCD clocks apart.
- R6: When several gaps apply, the command waits only for the longest one. The gaps never add: a write to rank 0 followed by a read to rank 1 is 6 clocks apart, not 6 + tCCD.
- R7: Reset clears all spacing history, so the first command presented after reset issues in the same cycle it is presented.
- R8: `cmd_valid` is high exactly when a request is pending and all its gaps have run out. The command is taken (`req_ready` high) only in a cycle where `phy_ready` is also high. While `phy_ready` is low, the offered command stays on `cmd_is_wr`/`cmd_rank` unchanged. The bench encodes `req_is_wr` as 1 = write, 0 = read, and `req_rank` as a binary rank number.
- R9: A command issues in the first cycle in which all its gaps have run out and `phy_ready` is high. It is never held longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all spacing history |
| cfg_rl | input | CFG_W | Read latency in clocks |
| cfg_wl | input | CFG_W | Write latency in clocks |
| cfg_bl | input | CFG_W | Burst length in beats (halved internally) |
| cfg_twtr | input | CFG_W | Same-rank write-to-read recovery in clocks |
| cfg_tccd | input | CFG_W | Minimum spacing between any two column commands |
| req_valid | input | 1 | Scheduler presents a command |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_rank | input | RANK_W | Target rank |
| req_ready | output | 1 | Command accepted and issued this cycle |
| cmd_valid | output | 1 | Command offered to the PHY path |
| cmd_is_wr | output | 1 | Offered command type |
| cmd_rank | output | RANK_W | Offered command rank |
| phy_ready | input | 1 | PHY path can take a command |

## Verification
The assertions keep independent cycles-since counters for the last read, the last write and the last command. On every cycle they check that no issued command breaks the read-to-write, rank-switch, same-rank write-to-read or column spacing, and that a reload never shortens time already owed. These checks show only that commands are never too early. Only the bench can show that a command is never held too long: it measures the exact gap between consecutive issues over a mix of rank and type sequences. The bench also covers the immediate issue after reset, and the stalls that come from a back-pressured PHY path.

// File: rtl/cas_gate_pkg.sv
package cas_gate_pkg;

   typedef enum logic {
      CAS_READ  = 1'b0,
      CAS_WRITE = 1'b1
   } cas_kind_e;

   function automatic int rank_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cas_gap_calc.sv
module cas_gap_calc #(
   parameter int CFG_W      = 6,
   parameter int GAP_W      = 8,
   parameter int R2W_MARGIN = 4
) (
   input  logic [CFG_W-1:0] cfg_rl,
   input  logic [CFG_W-1:0] cfg_wl,
   input  logic [CFG_W-1:0] cfg_bl,
   input  logic [CFG_W-1:0] cfg_twtr,
   input  logic [CFG_W-1:0] cfg_tccd,
   output logic [GAP_W-1:0] r2w_gap,
   output logic [GAP_W-1:0] wtr_gap,
   output logic [GAP_W-1:0] ccd_gap
);

   if (GAP_W < CFG_W + 2) begin : g_bad_gap_w
      $error("cas_gap_calc: GAP_W must be at least CFG_W + 2");
   end
   if (R2W_MARGIN < 0 || R2W_MARGIN >= (1 << CFG_W)) begin : g_bad_margin
      $error("cas_gap_calc: R2W_MARGIN out of range");
   end

   logic [GAP_W-1:0] rl_x, wl_x, half_bl, rd_end;

   always_comb begin
      rl_x    = GAP_W'(cfg_rl);
      wl_x    = GAP_W'(cfg_wl);
      half_bl = GAP_W'(cfg_bl >> 1);
      // end of read data on the bus, with board margin added
      rd_end  = rl_x + half_bl + GAP_W'(R2W_MARGIN);
      r2w_gap = (rd_end > wl_x) ? (rd_end - wl_x) : '0;
      wtr_gap = wl_x + half_bl + GAP_W'(cfg_twtr);
      ccd_gap = GAP_W'(cfg_tccd);
   end

endmodule

// File: rtl/cas_gap_timer.sv
module cas_gap_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] gap,
   output logic         expired
);

   if (W < 2) begin : g_bad_w
      $error("cas_gap_timer: W must be at least 2");
   end

   logic [W-1:0] cnt, dec, ld;

   // a gap of G means the next command may go G cycles after the load edge
   always_comb begin
      dec = (cnt == '0) ? '0 : cnt - W'(1);
      ld  = (gap == '0) ? '0 : gap - W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= (ld > dec) ? ld : dec;
      else           cnt <= dec;
   end

   assign expired = (cnt == '0);

   // R6: a reload keeps whatever wait was already owed
   assert_no_shorten_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ({1'b0, cnt} + (W+1)'(1) >= {1'b0, $past(cnt)}) &&
               ({1'b0, cnt} + (W+1)'(1) >= {1'b0, $past(gap)}));

endmodule

// File: rtl/cas_spacing_gate.sv
module cas_spacing_gate
   import cas_gate_pkg::*;
#(
   parameter int NUM_RANKS       = 4,
   parameter int CFG_W           = 6,
   parameter int RANK_SWITCH_GAP = 6,
   parameter int R2W_MARGIN      = 4,
   localparam int RANK_W         = rank_bits(NUM_RANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_rl,
   input  logic [CFG_W-1:0]  cfg_wl,
   input  logic [CFG_W-1:0]  cfg_bl,
   input  logic [CFG_W-1:0]  cfg_twtr,
   input  logic [CFG_W-1:0]  cfg_tccd,
   input  logic              req_valid,
   input  logic              req_is_wr,
   input  logic [RANK_W-1:0] req_rank,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic              cmd_is_wr,
   output logic [RANK_W-1:0] cmd_rank,
   input  logic              phy_ready
);

   localparam int GAP_W = CFG_W + 2;
   localparam int SW    = GAP_W + 1;

   if (!(NUM_RANKS == 1 || NUM_RANKS == 2 || NUM_RANKS == 4)) begin : g_bad_ranks
      $error("cas_spacing_gate: NUM_RANKS must be 1, 2 or 4");
   end
   if (RANK_SWITCH_GAP < 1 || RANK_SWITCH_GAP >= (1 << GAP_W)) begin : g_bad_switch
      $error("cas_spacing_gate: RANK_SWITCH_GAP out of range");
   end

   cas_kind_e        kind;
   logic             fire, allowed, ccd_ok, wr_ok, rd_ok_sel;
   logic             rd_ok [NUM_RANKS];
   logic [GAP_W-1:0] r2w_gap, wtr_gap, ccd_gap;

   assign kind = cas_kind_e'(req_is_wr);

   cas_gap_calc #(
      .CFG_W(CFG_W), .GAP_W(GAP_W), .R2W_MARGIN(R2W_MARGIN)
   ) u_calc (
      .cfg_rl(cfg_rl), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl),
      .cfg_twtr(cfg_twtr), .cfg_tccd(cfg_tccd),
      .r2w_gap(r2w_gap), .wtr_gap(wtr_gap), .ccd_gap(ccd_gap)
   );

   // column-to-column spacing, any type, any rank
   cas_gap_timer #(.W(GAP_W)) u_ccd (
      .clk(clk), .rst_n(rst_n), .load(fire), .gap(ccd_gap), .expired(ccd_ok)
   );

   // read-to-write spacing, all ranks share the data bus
   cas_gap_timer #(.W(GAP_W)) u_r2w (
      .clk(clk), .rst_n(rst_n), .load(fire && (kind == CAS_READ)),
      .gap(r2w_gap), .expired(wr_ok)
   );

   // per-rank read blocking
   if (NUM_RANKS == 1) begin : g_single
      cas_gap_timer #(.W(GAP_W)) u_rd (
         .clk(clk), .rst_n(rst_n), .load(fire && (kind == CAS_WRITE)),
         .gap(wtr_gap), .expired(rd_ok[0])
      );
      assign rd_ok_sel = rd_ok[0];
   end else begin : g_multi
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
         logic             same, ld;
         logic [GAP_W-1:0] g;
         always_comb begin
            same = (req_rank == RANK_W'(r));
            ld   = fire && ((kind == CAS_WRITE) || !same);
            g    = ((kind == CAS_WRITE) && same) ? wtr_gap : GAP_W'(RANK_SWITCH_GAP);
         end
         cas_gap_timer #(.W(GAP_W)) u_rd (
            .clk(clk), .rst_n(rst_n), .load(ld), .gap(g), .expired(rd_ok[r])
         );
      end
      assign rd_ok_sel = rd_ok[req_rank];
   end

   always_comb begin
      allowed   = ccd_ok && ((kind == CAS_WRITE) ? wr_ok : rd_ok_sel);
      cmd_valid = req_valid && allowed;
      fire      = cmd_valid && phy_ready;
      req_ready = fire;
      cmd_is_wr = req_is_wr;
      cmd_rank  = req_rank;
   end

   // ---------------- independent spacing observers ----------------
   logic [SW-1:0]     since_rd, since_wr, since_any;
   logic              seen_rd, seen_wr, seen_any;
   logic [RANK_W-1:0] last_rd_rank, last_wr_rank;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rd <= '0; since_wr <= '0; since_any <= '0;
         seen_rd <= 1'b0; seen_wr <= 1'b0; seen_any <= 1'b0;
         last_rd_rank <= '0; last_wr_rank <= '0;
      end else begin
         since_rd  <= (since_rd  == '1) ? since_rd  : since_rd  + SW'(1);
         since_wr  <= (since_wr  == '1) ? since_wr  : since_wr  + SW'(1);
         since_any <= (since_any == '1) ? since_any : since_any + SW'(1);
         if (fire) begin
            since_any <= SW'(1);
            seen_any  <= 1'b1;
            if (req_is_wr) begin
               since_wr <= SW'(1); seen_wr <= 1'b1; last_wr_rank <= req_rank;
            end else begin
               since_rd <= SW'(1); seen_rd <= 1'b1; last_rd_rank <= req_rank;
            end
         end
      end
   end

   assert_r2w_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && req_is_wr && seen_rd) |-> (since_rd >= {1'b0, r2w_gap}));

   assert_rd_rank_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_is_wr && seen_rd && (req_rank != last_rd_rank))
      |-> (since_rd >= SW'(RANK_SWITCH_GAP)));

   assert_wr_rd_rank_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_is_wr && seen_wr && (req_rank != last_wr_rank))
      |-> (since_wr >= SW'(RANK_SWITCH_GAP)));

   assert_wr_rd_same_rank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_is_wr && seen_wr && (req_rank == last_wr_rank))
      |-> (since_wr >= {1'b0, wtr_gap}));

   assert_ccd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && seen_any) |-> (since_any >= {1'b0, ccd_gap}));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !phy_ready && $stable(req_is_wr) && $stable(req_rank) && req_valid)
      |=> cmd_valid);

endmodule

// File: tb/test_cas_spacing_gate.sv
module test_cas_spacing_gate;

   localparam int RL = 11, WL = 9, BL = 8, TWTR = 6, TCCD = 4;
   localparam int E_CCD = TCCD;
   localparam int E_R2W = RL + BL/2 + 4 - WL;   // 10
   localparam int E_WTR = WL + BL/2 + TWTR;     // 19
   localparam int E_SW  = 6;
   localparam int NV    = 12;

   // rows follow an initial read to rank 0; gap = clocks from previous issue
   localparam int V_WR  [NV] = '{0, 0, 1, 1, 0, 1, 0, 1, 1, 0, 0, 0};
   localparam int V_RK  [NV] = '{0, 1, 1, 1, 2, 2, 2, 3, 0, 3, 0, 1};
   localparam int V_GAP [NV] = '{
      E_CCD,          // R5 read after read, same rank
      E_SW,           // R2 read rank switch
      E_R2W,          // R1 write after read
      E_CCD,          // R5 write after write, same rank
      E_SW,           // R3 R6 read after write to other rank, not summed
      E_R2W,          // R1
      E_WTR,          // R4 read after write, same rank
      E_R2W,          // R1
      E_CCD,          // R5 write after write, other rank
      E_WTR - E_CCD,  // R4 R6 older same-rank write dominates
      E_SW,           // R2 rank switch dominates older write
      E_SW            // R2
   };
   localparam int V_REQ [NV] = '{5, 2, 1, 5, 3, 1, 4, 1, 5, 4, 2, 2};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_is_wr = 1'b0, phy_ready = 1'b1;
   logic [1:0] req_rank = '0;
   logic       req_ready, cmd_valid, cmd_is_wr;
   logic [1:0] cmd_rank;
   int         cyc = 0;
   int         checks = 0, errors = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cas_spacing_gate #(.NUM_RANKS(4), .CFG_W(6)) i_cas_spacing_gate (
      .clk(clk), .rst_n(rst_n),
      .cfg_rl(6'(RL)), .cfg_wl(6'(WL)), .cfg_bl(6'(BL)),
      .cfg_twtr(6'(TWTR)), .cfg_tccd(6'(TCCD)),
      .req_valid(req_valid), .req_is_wr(req_is_wr), .req_rank(req_rank),
      .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
      .cmd_rank(cmd_rank), .phy_ready(phy_ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // present a command, return cycle it was presented and cycle it issued
   task automatic send(input int wr, input int rk, output int pres, output int fired);
      int n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_is_wr = wr[0]; req_rank = rk[1:0];
      #1;
      pres = cyc;
      while (!(cmd_valid && phy_ready && req_ready) && n < 200) begin
         @(negedge clk); #1; n++;
      end
      fired = cyc;
      check(n < 200, "R9 timeout", n, 0);
      check(cmd_is_wr == wr[0] && cmd_rank == rk[1:0], "R8 fields",
            {cmd_is_wr, cmd_rank}, {wr[0], rk[1:0]});
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(cmd_valid == 1'b0 && req_ready == 1'b0, "R7 reset state",
            {cmd_valid, req_ready}, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int p, f, last;
      do_reset();

      // R7: first command after reset issues at once
      send(0, 0, p, f);
      check(f == p, "R7 first issue delay", f - p, 0);
      last = f;

      // vector table walk: exact gap proves both minimum and no over-wait (R9)
      for (int i = 0; i < NV; i++) begin
         send(V_WR[i], V_RK[i], p, f);
         check(f - last == V_GAP[i], $sformatf("R%0d row %0d gap", V_REQ[i], i),
               f - last, V_GAP[i]);
         last = f;
      end

      // R8: PHY back-pressure holds an allowed write
      phy_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_is_wr = 1'b1; req_rank = 2'd0;
      repeat (15) @(negedge clk);
      #1;
      check(cmd_valid == 1'b1, "R8 offered while stalled", cmd_valid, 1);
      check(req_ready == 1'b0, "R8 not taken while stalled", req_ready, 0);
      check(cmd_is_wr == 1'b1 && cmd_rank == 2'd0, "R8 held fields",
            {cmd_is_wr, cmd_rank}, 4);
      @(negedge clk);
      phy_ready = 1'b1;
      #1;
      check(req_ready == 1'b1, "R9 issues as soon as PHY ready", req_ready, 1);
      last = cyc;
      @(posedge clk); #1;
      req_valid = 1'b0;

      // R4 after a stalled write: gap counts from its actual issue
      send(0, 0, p, f);
      check(f - last == E_WTR, "R4 read after stalled write", f - last, E_WTR);

      // R7: reset wipes a pending same-rank write-to-read wait
      send(1, 1, p, f);
      do_reset();
      send(0, 1, p, f);
      check(f == p, "R7 history cleared", f - p, 0);
      last = f;

      // R1 right after reset history
      send(1, 2, p, f);
      check(f - last == E_R2W, "R1 write after read", f - last, E_R2W);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule